// File: doc/BRIEF.md
# Quadruplet Centroid Averager with Layer Rejection

This block forms one space point from the four layer centroids of a detector quadruplet. Each layer supplies a centroid and a flag saying whether its strip width passed upstream. It also supplies three quality measures: the cluster width in strips, the cluster charge and a pileup marker. A layer that fails any quality cut is dropped. The centroids of the remaining layers are summed and divided by the number kept. The result is an average in the same fixed-point scale as the inputs. Centroids are unsigned values in which the low 18 bits are the fraction of a strip.

From one event to the next, zero to four layers may survive. The divisor is therefore 1, 2, 3 or 4. Division by 1, 2 and 4 is done by selecting bits. Division by 3 uses a multiply by a fixed reciprocal, or optionally a constant divider. The block takes one event per clock and has a fixed pipeline latency of three cycles. The charge ceiling comes in on a configuration input and is applied to each event as it enters.

Top module: `qca_quad_avg`

## Requirements
- R1: A layer whose width-valid flag (bit i of `in_wvalid` for layer i) is low is never included in the average.
- R2: A layer whose cluster width (`in_width[4i+3:4i]`) exceeds MAX_STRIPS (default 5) is rejected; a width of exactly 5 is accepted.
- R3: A layer with a cluster width of 0 or 1 strip is rejected as noise; a width of 2 is accepted.
- R4: A layer whose charge (`in_charge[12i+11:12i]`) is greater than `cfg_qmax` is rejected; a charge equal to `cfg_qmax` is accepted.
- R5: A layer whose pileup bit (bit i of `in_pileup`) is high is rejected.
- R6: `out_nlayers` equals the number of layers that passed every cut, from 0 to 4.
- R7: `out_centroid` equals the floor of the sum of the kept centroids divided by their count, exactly, for every count from 1 to 4, including full-scale inputs.
- R8: When no layer is kept, `out_point_ok` is low and `out_centroid` is zero; otherwise `out_point_ok` is high whenever `out_vld` is high.
- R9: An event presented with `in_vld` high at a clock edge appears with `out_vld` high exactly three edges later. Events may arrive on consecutive cycles, and `out_vld` is low for cycles with no input event.
- R10: While `rst_n` is low, `out_vld`, `out_point_ok`, `out_nlayers` and `out_centroid` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_qmax | input | QW (12) | Largest charge a layer may carry and still be kept |
| in_vld | input | 1 | An event is present on the inputs |
| in_cent | input | 4*CW (192) | Layer centroids; layer i at bits [CW*i +: CW] |
| in_wvalid | input | 4 | Per-layer width-valid flags |
| in_width | input | 4*WW (16) | Per-layer cluster width in strips |
| in_charge | input | 4*QW (48) | Per-layer cluster charge |
| in_pileup | input | 4 | Per-layer pileup markers |
| out_vld | output | 1 | A result is present |
| out_point_ok | output | 1 | At least one layer was kept |
| out_nlayers | output | 3 | Number of layers kept |
| out_centroid | output | CW (48) | Averaged centroid |

## Verification
The assertions assume that `in_vld` is held low and known throughout reset. They also assume that every input is a known value at each rising edge. The latency and rejection properties compare outputs against inputs sampled three edges earlier, so they count on events entering only through `in_vld`, with no back-pressure. The stimulus meets this by changing inputs only on falling edges, starting from all-zero values, and keeping `in_vld` low until reset is released. Changes to `cfg_qmax` are made together with an event's other inputs, because the ceiling is applied at entry.

// File: rtl/qca_pkg.sv
package qca_pkg;
   localparam int unsigned NLAYER = 4;
   localparam int unsigned CNT_W  = $clog2(NLAYER + 1);
endpackage

// File: rtl/qca_layer_screen.sv
module qca_layer_screen #(
   parameter int unsigned WW         = 4,
   parameter int unsigned QW         = 12,
   parameter int unsigned MAX_STRIPS = 5
) (
   input  logic          wvalid,
   input  logic [WW-1:0] width,
   input  logic [QW-1:0] charge,
   input  logic          pileup,
   input  logic [QW-1:0] qmax,
   output logic          keep
);
   localparam logic [WW-1:0] WMAX = WW'(MAX_STRIPS);
   localparam logic [WW-1:0] WMIN = WW'(2);

   logic width_ok;
   logic charge_ok;

   always_comb begin
      width_ok  = (width >= WMIN) && (width <= WMAX);
      charge_ok = (charge <= qmax);
      keep      = wvalid && !pileup && width_ok && charge_ok;
   end
endmodule

// File: rtl/qca_accum.sv
module qca_accum
   import qca_pkg::*;
#(
   parameter int unsigned CW = 48,
   localparam int unsigned SW = CW + 2
) (
   input  logic [NLAYER-1:0]    keep,
   input  logic [NLAYER*CW-1:0] cent,
   output logic [SW-1:0]        sum,
   output logic [CNT_W-1:0]     cnt
);
   always_comb begin
      sum = '0;
      cnt = '0;
      for (int i = 0; i < int'(NLAYER); i++) begin
         if (keep[i]) begin
            sum = sum + {2'b00, cent[i*CW +: CW]};
            cnt = cnt + CNT_W'(1);
         end
      end
   end
endmodule

// File: rtl/qca_divider.sv
module qca_divider
   import qca_pkg::*;
#(
   parameter int unsigned CW    = 48,
   parameter bit          RECIP = 1'b1,
   localparam int unsigned SW = CW + 2
) (
   input  logic [SW-1:0]    sum,
   input  logic [CNT_W-1:0] cnt,
   output logic [CW-1:0]    quo
);
   logic [CW-1:0] third;

   generate
      if (RECIP) begin : g_recip
         // Even shift K >= SW+2 keeps floor(x*M/2^K) exact for x < 2^(K-1)
         localparam int unsigned K = ((SW + 2) % 2 == 0) ? (SW + 2) : (SW + 3);
         localparam logic [K-1:0] M = {(K/2){2'b01}} + K'(1);
         logic [SW+K-1:0] prod;
         always_comb begin
            prod  = {{K{1'b0}}, sum} * {{SW{1'b0}}, M};
            third = prod[K +: CW];
         end
      end else begin : g_const
         logic [SW-1:0] q3;
         always_comb begin
            q3    = sum / SW'(3);
            third = q3[CW-1:0];
         end
      end
   endgenerate

   always_comb begin
      case (cnt)
         CNT_W'(1): quo = sum[CW-1:0];
         CNT_W'(2): quo = sum[CW:1];
         CNT_W'(3): quo = third;
         CNT_W'(4): quo = sum[CW+1:2];
         default:   quo = '0;
      endcase
   end
endmodule

// File: rtl/qca_quad_avg.sv
module qca_quad_avg
   import qca_pkg::*;
#(
   parameter int unsigned CW         = 48,
   parameter int unsigned WW         = 4,
   parameter int unsigned QW         = 12,
   parameter int unsigned MAX_STRIPS = 5,
   parameter bit          RECIP      = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [QW-1:0]        cfg_qmax,
   input  logic                 in_vld,
   input  logic [4*CW-1:0]      in_cent,
   input  logic [3:0]           in_wvalid,
   input  logic [4*WW-1:0]      in_width,
   input  logic [4*QW-1:0]      in_charge,
   input  logic [3:0]           in_pileup,
   output logic                 out_vld,
   output logic                 out_point_ok,
   output logic [2:0]           out_nlayers,
   output logic [CW-1:0]        out_centroid
);
   localparam int unsigned SW = CW + 2;

   if (CW < 20) begin : g_bad_cw
      $error("qca_quad_avg: CW too small for the fixed-point scale");
   end
   if (MAX_STRIPS < 2 || MAX_STRIPS >= (1 << WW)) begin : g_bad_strips
      $error("qca_quad_avg: MAX_STRIPS must lie in [2, 2**WW-1]");
   end
   if (NLAYER != 4 || CNT_W != 3) begin : g_bad_layers
      $error("qca_quad_avg: divider supports exactly four layers");
   end

   // Stage A: layer screening
   logic [NLAYER-1:0]    keep_d;
   logic [NLAYER-1:0]    a_keep;
   logic [NLAYER*CW-1:0] a_cent;
   logic                 a_vld;

   for (genvar g = 0; g < int'(NLAYER); g++) begin : g_screen
      qca_layer_screen #(.WW(WW), .QW(QW), .MAX_STRIPS(MAX_STRIPS)) u_scr (
         .wvalid (in_wvalid[g]),
         .width  (in_width[g*WW +: WW]),
         .charge (in_charge[g*QW +: QW]),
         .pileup (in_pileup[g]),
         .qmax   (cfg_qmax),
         .keep   (keep_d[g])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         a_keep <= '0;
         a_cent <= '0;
         a_vld  <= 1'b0;
      end else begin
         a_keep <= keep_d;
         a_cent <= in_cent;
         a_vld  <= in_vld;
      end
   end

   // Stage B: masked sum and count
   logic [SW-1:0]    acc_sum;
   logic [CNT_W-1:0] acc_cnt;
   logic [SW-1:0]    b_sum;
   logic [CNT_W-1:0] b_cnt;
   logic             b_vld;

   qca_accum #(.CW(CW)) u_acc (
      .keep (a_keep),
      .cent (a_cent),
      .sum  (acc_sum),
      .cnt  (acc_cnt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         b_sum <= '0;
         b_cnt <= '0;
         b_vld <= 1'b0;
      end else begin
         b_sum <= acc_sum;
         b_cnt <= acc_cnt;
         b_vld <= a_vld;
      end
   end

   // Stage C: divide by the kept count
   logic [CW-1:0] div_q;

   qca_divider #(.CW(CW), .RECIP(RECIP)) u_div (
      .sum (b_sum),
      .cnt (b_cnt),
      .quo (div_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_vld      <= 1'b0;
         out_point_ok <= 1'b0;
         out_nlayers  <= '0;
         out_centroid <= '0;
      end else begin
         out_vld      <= b_vld;
         out_point_ok <= b_vld && (b_cnt != '0);
         out_nlayers  <= b_cnt;
         out_centroid <= div_q;
      end
   end
endmodule

// File: rtl/qca_quad_avg_chk.sv
module qca_quad_avg_chk #(
   parameter int unsigned CW = 48,
   parameter int unsigned WW = 4,
   parameter int unsigned QW = 12
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_vld,
   input logic [3:0]        in_wvalid,
   input logic [3:0]        in_pileup,
   input logic              out_vld,
   input logic              out_point_ok,
   input logic [2:0]        out_nlayers,
   input logic [CW-1:0]     out_centroid
);
   logic [1:0] cyc;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cyc <= '0;
      else if (cyc != 2'd3) cyc <= cyc + 2'd1;
   end

   // R9
   latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc == 2'd3) |-> (out_vld == $past(in_vld, 3)));

   // R8
   empty_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_vld && out_nlayers == 3'd0) |-> (!out_point_ok && out_centroid == '0));

   // R8
   ok_needs_layer_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_point_ok |-> (out_vld && out_nlayers != 3'd0));

   // R6
   count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_vld |-> (out_nlayers <= 3'd4));

   // R1
   no_width_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc == 2'd3 && $past(in_vld, 3) && $past(in_wvalid, 3) == 4'b0000)
      |-> (out_vld && out_nlayers == 3'd0));

   // R5
   all_pileup_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc == 2'd3 && $past(in_vld, 3) && $past(in_pileup, 3) == 4'b1111)
      |-> (out_vld && !out_point_ok));
endmodule

bind qca_quad_avg qca_quad_avg_chk #(.CW(CW), .WW(WW), .QW(QW)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .in_vld       (in_vld),
   .in_wvalid    (in_wvalid),
   .in_pileup    (in_pileup),
   .out_vld      (out_vld),
   .out_point_ok (out_point_ok),
   .out_nlayers  (out_nlayers),
   .out_centroid (out_centroid)
);

// File: tb/tb_qca_quad_avg.sv
module tb_qca_quad_avg;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [11:0]  cfg_qmax = '0;
   logic         in_vld = 1'b0;
   logic [191:0] in_cent = '0;
   logic [3:0]   in_wvalid = '0;
   logic [15:0]  in_width = '0;
   logic [47:0]  in_charge = '0;
   logic [3:0]   in_pileup = '0;
   logic         out_vld;
   logic         out_point_ok;
   logic [2:0]   out_nlayers;
   logic [47:0]  out_centroid;

   int errors = 0;
   int checks = 0;
   longint cyc = 0;

   typedef struct {
      logic [47:0] c;
      logic [2:0]  n;
      logic        ok;
      longint      due;
      string       req;
   } exp_t;
   exp_t sb[$];

   always #2 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   qca_quad_avg dut (
      .clk(clk), .rst_n(rst_n), .cfg_qmax(cfg_qmax), .in_vld(in_vld),
      .in_cent(in_cent), .in_wvalid(in_wvalid), .in_width(in_width),
      .in_charge(in_charge), .in_pileup(in_pileup), .out_vld(out_vld),
      .out_point_ok(out_point_ok), .out_nlayers(out_nlayers),
      .out_centroid(out_centroid)
   );

   task automatic send(input logic [191:0] c, input logic [3:0] wv,
                       input logic [15:0] wd, input logic [47:0] q,
                       input logic [3:0] pu, input string req);
      logic [63:0] s;
      int n;
      exp_t e;
      @(negedge clk);
      s = 0;
      n = 0;
      for (int i = 0; i < 4; i++) begin
         logic [3:0] w;
         w = wd[i*4 +: 4];
         if (wv[i] && !pu[i] && w >= 2 && w <= 5 && q[i*12 +: 12] <= cfg_qmax) begin
            s = s + {16'd0, c[i*48 +: 48]};
            n++;
         end
      end
      e.c   = (n == 0) ? 48'd0 : 48'(s / 64'(n));
      e.n   = 3'(n);
      e.ok  = (n != 0);
      e.due = cyc + 3;
      e.req = req;
      sb.push_back(e);
      in_vld    = 1'b1;
      in_cent   = c;
      in_wvalid = wv;
      in_width  = wd;
      in_charge = q;
      in_pileup = pu;
   endtask

   task automatic idle(input int k);
      for (int i = 0; i < k; i++) begin
         @(negedge clk);
         in_vld = 1'b0;
      end
   endtask

   // Monitor: pop and compare each result
   always @(posedge clk) begin
      #1;
      if (rst_n && out_vld) begin
         checks++;
         if (sb.size() == 0) begin
            errors++;
            $display("FAIL R9: unexpected out_vld actual=1 expected=0");
         end else begin
            exp_t e;
            e = sb.pop_front();
            if (cyc != e.due) begin
               errors++;
               $display("FAIL R9: result cycle actual=%0d expected=%0d", cyc, e.due);
            end
            if (out_nlayers != e.n || out_point_ok != e.ok || out_centroid != e.c) begin
               errors++;
               $display("FAIL %s: actual n=%0d ok=%0b c=%0d expected n=%0d ok=%0b c=%0d",
                        e.req, out_nlayers, out_point_ok, out_centroid, e.n, e.ok, e.c);
            end
         end
      end
   end

   initial begin
      #400000;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   localparam logic [47:0] FS = 48'hFFFF_FFFF_FFFF;

   initial begin
      repeat (3) @(negedge clk);
      checks++;
      // R10 reset state
      if (out_vld !== 1'b0 || out_point_ok !== 1'b0 || out_nlayers !== 3'd0 || out_centroid !== 48'd0) begin
         errors++;
         $display("FAIL R10: actual vld=%b ok=%b n=%0d c=%0d expected all zero",
                  out_vld, out_point_ok, out_nlayers, out_centroid);
      end
      rst_n = 1'b1;
      cfg_qmax = 12'd100;
      // R7 R6 all kept
      send({48'd4000, 48'd3000, 48'd2000, 48'd1000}, 4'hF, 16'h3333, {4{12'd50}}, 4'h0, "R7");
      // R1 layer 2 not width-valid, divide by 3
      send({48'd4000, 48'd3000, 48'd2000, 48'd1000}, 4'b1011, 16'h3333, {4{12'd50}}, 4'h0, "R1");
      // R2 width 6 rejected, width 5 kept
      send({48'd4000, 48'd3000, 48'd2000, 48'd1000}, 4'hF, 16'h3356, {4{12'd50}}, 4'h0, "R2");
      // R3 widths 0 and 1 rejected, 2 kept
      send({48'd4000, 48'd3000, 48'd2000, 48'd1000}, 4'hF, 16'h1203, {4{12'd50}}, 4'h0, "R3");
      // R4 charge 101 rejected, 100 kept
      send({48'd4000, 48'd3000, 48'd2000, 48'd1000}, 4'hF, 16'h3333,
           {12'd10, 12'd20, 12'd101, 12'd100}, 4'h0, "R4");
      // R5 pileup rejection
      send({48'd4000, 48'd3000, 48'd2000, 48'd1000}, 4'hF, 16'h3333, {4{12'd50}}, 4'b0011, "R5");
      // R6 single layer kept
      send({48'd4000, 48'd3000, 48'd2000, 48'd1000}, 4'b0100, 16'h3333, {4{12'd50}}, 4'h0, "R6");
      // R8 all rejected by mixed causes
      send({48'd4000, 48'd3000, 48'd2000, 48'd1000}, 4'b1110, 16'h6133,
           {12'd10, 12'd10, 12'd10, 12'd10}, 4'b0010, "R8");
      // R1 no layer width-valid
      send({48'd4000, 48'd3000, 48'd2000, 48'd1000}, 4'h0, 16'h3333, {4{12'd50}}, 4'h0, "R1");
      // R7 full scale, counts 3, 4, 2
      send({FS, FS, FS, FS}, 4'b0111, 16'h3333, {4{12'd50}}, 4'h0, "R7");
      send({FS, FS, FS, FS}, 4'hF, 16'h5555, {4{12'd100}}, 4'h0, "R7");
      send({48'd0, 48'd0, FS - 48'd1, FS}, 4'b0011, 16'h2222, {4{12'd0}}, 4'h0, "R7");
      // R7 remainder on divide by 3
      send({48'd9, 48'd6, 48'd5, 48'd5}, 4'b0111, 16'h3333, {4{12'd1}}, 4'h0, "R7");
      idle(2);
      // R4 ceiling at full range
      cfg_qmax = 12'hFFF;
      send({48'd70, 48'd50, 48'd30, 48'd10}, 4'hF, 16'h4444, {4{12'hFFF}}, 4'h0, "R4");
      idle(3);
      cfg_qmax = 12'd150;
      // R9 back-to-back stream with patterned inputs
      for (int i = 0; i < 40; i++) begin
         logic [191:0] c;
         logic [3:0] wv;
         logic [3:0] pu;
         logic [15:0] wd;
         logic [47:0] q;
         for (int j = 0; j < 4; j++) begin
            c[j*48 +: 48] = 48'(i * 7919 * (j + 3) + j * 262144 + 48'h1_0000_0000 * i);
            wv[j]         = ((i * 3 + j) % 6) != 0;
            pu[j]         = ((i + j) % 5) == 0;
            wd[j*4 +: 4]  = 4'((i + 2 * j) % 8);
            q[j*12 +: 12] = 12'((i * 37 + j * 11) % 200);
         end
         send(c, wv, wd, q, pu, "R9");
         if (i % 9 == 8) idle(1);
      end
      idle(8);
      checks++;
      if (sb.size() != 0) begin
         errors++;
         $display("FAIL R9: pending results actual=%0d expected=0", sb.size());
      end
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule